// File: doc/BRIEF.md
# SPI Master with Extended Phase Modes

This block is a single-lane SPI master. It clocks a programmed number of bytes out on MOSI and, at the same time, collects bytes from MISO for one slave. Bytes are eight bits, sent MSB first. A start pulse launches a transfer of `xfer_len` bytes. The first `prepend_len` of them are transmit-only: their received bits are thrown away. Every byte after them is handed back on a one-cycle receive strobe. Transmit bytes come in through a valid/ready handshake, one byte at a time. Chip-select stays low for the whole transfer. The transfer ends with a one-cycle done pulse.

The clock shape comes from the upper three bits of a control word together with a two-bit mode number. The mode selects clock polarity and phase. The control word adds a valid flag, a phase-extension bit and an idle-clock gating bit. With phase extension set, data can be launched and latched on the same SCLK edge, which gives four modes beyond the usual four. When the valid flag is clear, the rest of the setting is ignored and a default applies. This lets software tell "use defaults" apart from an explicit all-zero setting. When gating is off, SCLK runs freely at the divided rate while chip-select is high. Before a transfer starts, the block waits until SCLK is back at its idle level.

Top module: `spi_xmode_master`

## Requirements
- R1: After reset, cs_n and sclk are at their default levels: cs_n is 1 and sclk is 0. The outputs done, err, rx_valid and tx_ready are all 0.
- R2: When cs_n falls and when it rises, sclk is at the idle level given by CPOL. The first SCLK edge of every byte moves sclk away from that idle level.
- R3: The latch edge is the edge leaving idle when CPHA=0, and the edge returning to idle when CPHA=1. Data is launched on the edge leaving idle exactly when CPHA differs from EXT. When launch and latch fall on the same edge, MISO is sampled before MOSI moves to the next bit.
- R4: Control inputs: `ctrl_hi[2]` is control-word bit 31 (valid), `ctrl_hi[1]` is bit 30 (phase extension) and `ctrl_hi[0]` is bit 29 (idle-clock gating). `mode[0]` is CPHA and `mode[1]` is CPOL.
- R5: When `ctrl_hi[2]` is 0, the block uses CPOL=0, CPHA=0, EXT=0 with gating on, whatever the values of `mode` and the other control bits.
- R6: With gating on, sclk holds the CPOL level while cs_n is high. With gating off, sclk toggles every `clk_div`+1 clock cycles while idle.
- R7: Each byte takes 16 SCLK edges. Edges within a byte are `clk_div`+1 clock cycles apart. MOSI carries the byte MSB first. MOSI changes only on a launch edge, or when a new byte is loaded.
- R8: The first `prepend_len` bytes produce no rx_valid. Each later byte produces exactly one rx_valid, with rx_data equal to the byte received MSB first.
- R9: tx_ready is high only while cs_n is low and the block is waiting for the next byte. A byte is taken in the cycle where tx_valid and tx_ready are both high. Exactly `xfer_len` bytes are taken per transfer.
- R10: done is a single-cycle pulse, raised in the same cycle that cs_n returns high after the last byte.
- R11: A start with `xfer_len` equal to 0 raises err for one cycle, one cycle later. It leaves cs_n high and raises no done.
- R12: The clock configuration, lengths and divider are captured at start. Changing `ctrl_hi`, `mode`, `xfer_len` or `prepend_len` during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| ctrl_hi | input | 3 | Control-word bits 31..29: valid, phase extension, idle-clock gating |
| mode | input | 2 | SPI mode number: bit 1 CPOL, bit 0 CPHA |
| clk_div | input | DIV_W | SCLK half period minus one, in clk cycles |
| xfer_len | input | LEN_W | Bytes in the transfer |
| prepend_len | input | LEN_W | Leading bytes whose received data is dropped |
| tx_data | input | W | Next byte to transmit |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_ready | output | 1 | Block is waiting for the next byte |
| rx_data | output | W | Received byte, valid with rx_valid |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | Active-low chip-select |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle pulse for a rejected zero-length start |

## Verification
Two situations are hard to reach from the ports. The first is the same-edge modes, where a latch and a launch land on one SCLK edge: a wrong ordering shows up only as a one-bit slip. The second is a start that arrives while a free-running clock sits away from its idle level. To cover both, the stimulus walks all eight polarity/phase/extension combinations with a slave model that moves MISO only after each latch edge. It issues starts at random phases of the free-running clock, and it inserts random stalls on tx_valid so that byte loads fall at varying points. MOSI is checked against the expected launch edges cycle by cycle, not only by the byte values it carries.

// File: rtl/spi_xm_pkg.sv
package spi_xm_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic ext;
    logic gate;
  } xm_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_LOAD,
    ST_SHIFT,
    ST_TAIL
  } xm_state_t;

  // ctrl_hi[2] = word bit 31 (valid), [1] = bit 30 (ext), [0] = bit 29 (gate)
  localparam int HI_VALID = 2;
  localparam int HI_EXT   = 1;
  localparam int HI_GATE  = 0;

  function automatic xm_cfg_t decode_cfg(input logic [2:0] hi, input logic [1:0] mode);
    xm_cfg_t c;
    if (hi[HI_VALID]) begin
      c.cpol = mode[1];
      c.cpha = mode[0];
      c.ext  = hi[HI_EXT];
      c.gate = hi[HI_GATE];
    end else begin
      c.cpol = 1'b0;
      c.cpha = 1'b0;
      c.ext  = 1'b0;
      c.gate = 1'b1;
    end
    return c;
  endfunction

  // latch on the edge that leaves the idle level?
  function automatic logic latch_on_lead(input logic cpha);
    return ~cpha;
  endfunction

  // launch on the edge that leaves the idle level?
  function automatic logic launch_on_lead(input logic cpha, input logic ext);
    return cpha ^ ext;
  endfunction

endpackage

// File: rtl/spi_xm_divider.sv
module spi_xm_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_xm_shifter.sv
module spi_xm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         latch,
  input  logic         launch,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word,
  output logic         shift_fire
);

  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]     tx_sr, rx_sr;
  logic [CNT_W-1:0] lat_cnt, lat_cnt_nxt;
  logic             pend_q;

  // a launch only advances after the current bit has been latched
  assign lat_cnt_nxt = lat_cnt + (latch ? CNT_W'(1) : CNT_W'(0));
  assign shift_fire  = !load && launch && (pend_q || latch) && (lat_cnt_nxt < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      lat_cnt <= '0;
      pend_q  <= 1'b0;
    end else if (load) begin
      tx_sr   <= load_data;
      lat_cnt <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (latch) rx_sr <= {rx_sr[W-2:0], miso};
      lat_cnt <= lat_cnt_nxt;
      if (shift_fire) begin
        tx_sr  <= {tx_sr[W-2:0], 1'b0};
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_q | latch;
      end
    end
  end

  assign mosi    = tx_sr[W-1];
  assign rx_word = rx_sr;

endmodule

// File: rtl/spi_xmode_master.sv
module spi_xmode_master
  import spi_xm_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       ctrl_hi,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [LEN_W-1:0] prepend_len,
  input  logic [W-1:0]     tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [W-1:0]     rx_data,
  output logic             rx_valid,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             done,
  output logic             err
);

  localparam int HALF_W = $clog2(2 * W);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * W - 1);

  xm_state_t        state_q;
  xm_cfg_t          cfg_q, live_cfg;
  logic             sclk_q, cs_n_q, done_q, err_q, rxv_q;
  logic [HALF_W-1:0] half_q;
  logic [LEN_W-1:0] byte_q, len_q, pre_q;
  logic [DIV_W-1:0] div_q;

  // named internal events
  logic tick, div_restart, shift_tick, edge_lead;
  logic latch_ev, launch_ev, byte_end, last_byte;
  logic load_fire, in_idle, shift_fire;
  logic [DIV_W-1:0] div_sel;

  assign live_cfg    = decode_cfg(ctrl_hi, mode);
  assign in_idle     = (state_q == ST_IDLE);
  assign div_sel     = in_idle ? clk_div : div_q;
  assign div_restart = (state_q == ST_LOAD);
  assign shift_tick  = (state_q == ST_SHIFT) && tick;
  assign edge_lead   = ~half_q[0];
  assign latch_ev    = shift_tick && (edge_lead == latch_on_lead(cfg_q.cpha));
  assign launch_ev   = shift_tick && (edge_lead == launch_on_lead(cfg_q.cpha, cfg_q.ext));
  assign byte_end    = shift_tick && (half_q == HALF_LAST);
  assign last_byte   = (byte_q == len_q - 1'b1);
  assign load_fire   = (state_q == ST_LOAD) && tx_valid;
  assign tx_ready    = (state_q == ST_LOAD);

  spi_xm_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (div_restart),
    .div     (div_sel),
    .tick    (tick)
  );

  spi_xm_shifter #(.W(W)) u_shf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_fire),
    .load_data  (tx_data),
    .latch      (latch_ev),
    .launch     (launch_ev),
    .miso       (miso),
    .mosi       (mosi),
    .rx_word    (rx_data),
    .shift_fire (shift_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= decode_cfg(3'b000, 2'b00);
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      half_q  <= '0;
      byte_q  <= '0;
      len_q   <= '0;
      pre_q   <= '0;
      div_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rxv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rxv_q  <= byte_end && (byte_q >= pre_q);
      unique case (state_q)
        ST_IDLE: begin
          cfg_q <= live_cfg;
          div_q <= clk_div;
          if (live_cfg.gate) sclk_q <= live_cfg.cpol;
          else if (tick)     sclk_q <= ~sclk_q;
          if (start) begin
            if (xfer_len == '0) begin
              err_q <= 1'b1;
            end else begin
              len_q   <= xfer_len;
              pre_q   <= prepend_len;
              byte_q  <= '0;
              state_q <= ST_ALIGN;
            end
          end
        end
        ST_ALIGN: begin
          if (sclk_q == cfg_q.cpol) begin
            cs_n_q  <= 1'b0;
            state_q <= ST_LOAD;
          end else if (tick) begin
            sclk_q <= cfg_q.cpol;
          end
        end
        ST_LOAD: begin
          if (tx_valid) begin
            half_q  <= '0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            half_q <= half_q + 1'b1;
            if (byte_end) begin
              byte_q  <= byte_q + 1'b1;
              state_q <= last_byte ? ST_TAIL : ST_LOAD;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk     = sclk_q;
  assign cs_n     = cs_n_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rx_valid = rxv_q;

endmodule

// File: rtl/spi_xm_checker.sv
module spi_xm_checker #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             done,
  input logic             err,
  input logic             tx_ready,
  input logic             start,
  input logic [LEN_W-1:0] xfer_len,
  input logic             in_idle,
  input logic             cfg_cpol,
  input logic             cfg_gate,
  input logic             load_fire,
  input logic             shift_fire
);

  // R6: gated clock rests at the polarity level while deselected
  a_r6_gated_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cfg_gate) |-> (sclk == cfg_cpol));

  // R2: chip-select only asserts with the clock at its idle level
  a_r2_select_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (sclk == cfg_cpol));

  // R10: done accompanies the release of chip-select
  a_r10_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  // R11: a zero-length start is refused
  a_r11_zero_len_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && start && (xfer_len == '0)) |=> (err && cs_n));

  // R9: byte requests only inside a selected transfer
  a_r9_ready_inside: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !cs_n);

  // R7: MOSI moves only through a load or an accepted launch
  a_r7_mosi_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $past(load_fire || shift_fire));

endmodule

bind spi_xmode_master spi_xm_checker #(.LEN_W(LEN_W)) u_xm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .mosi       (mosi),
  .done       (done),
  .err        (err),
  .tx_ready   (tx_ready),
  .start      (start),
  .xfer_len   (xfer_len),
  .in_idle    (in_idle),
  .cfg_cpol   (cfg_q.cpol),
  .cfg_gate   (cfg_q.gate),
  .load_fire  (load_fire),
  .shift_fire (shift_fire)
);

// File: tb/test_spi_xmode_master.sv
module test_spi_xmode_master;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 8;

  logic       clk, rst_n, start, tx_valid, tx_ready, rx_valid;
  logic       sclk, cs_n, mosi, miso, done, err;
  logic [2:0] ctrl_hi;
  logic [1:0] mode;
  logic [7:0] clk_div, xfer_len, prepend_len, tx_data, rx_data;

  spi_xmode_master i_spi_xmode_master (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_hi(ctrl_hi), .mode(mode),
    .clk_div(clk_div), .xfer_len(xfer_len), .prepend_len(prepend_len),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench restatement of the requirements
  function automatic logic [3:0] exp_cfg(input logic [2:0] hi, input logic [1:0] m);
    // {cpol, cpha, ext, gate}
    if (!hi[2]) return 4'b0001;
    return {m[1], m[0], hi[1], hi[0]};
  endfunction

  function automatic bit exp_latch_lead(input logic cpha);
    return (cpha == 1'b0);
  endfunction

  function automatic bit exp_launch_lead(input logic cpha, input logic ext);
    case ({cpha, ext})
      2'b00:   return 1'b0;
      2'b10:   return 1'b1;
      2'b01:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // transfer stimulus and observations
  logic [7:0] tx_bytes [MAXB];
  logic [7:0] sl_bytes [MAXB];
  logic [7:0] mo_bytes [MAXB];
  logic [7:0] rx_got   [MAXB];
  int   n_len, n_div;
  logic e_cpol, e_cpha, e_ext;
  int   edges, mo_bits, rx_cnt, tx_idx, sl_bit, done_cnt;
  int   timing_bad, spacing_bad, cyc_since, stall;
  logic [7:0] mo_acc;
  bit   hs_prev;
  logic sclk_prev, mosi_prev, cs_prev;

  // monitor, transmit driver and slave model, all at the falling edge
  initial begin
    tx_valid = 1'b0; tx_data = 8'h00; miso = 1'b0;
    hs_prev = 1'b0; stall = 0;
    sclk_prev = 1'b0; mosi_prev = 1'b0; cs_prev = 1'b1;
    forever begin
      @(negedge clk);
      begin
        bit hs_last, tog, lead;
        hs_last = hs_prev;
        if (hs_prev) begin
          tx_idx++;
          stall = int'($urandom_range(0, 2));
        end
        if (stall > 0) begin
          tx_valid = 1'b0;
          stall--;
        end else begin
          tx_valid = (tx_idx < n_len);
          if (tx_idx < MAXB) tx_data = tx_bytes[tx_idx];
        end
        hs_prev = tx_valid && tx_ready;

        tog = !cs_n && !cs_prev && (sclk != sclk_prev);
        lead = (sclk != e_cpol);
        if (!cs_n && !cs_prev && (mosi != mosi_prev)) begin
          if (!(hs_last || (tog && (lead == exp_launch_lead(e_cpha, e_ext)))))
            timing_bad++;
        end
        if (tog) begin
          if ((edges % 16) != 0 && cyc_since != n_div) spacing_bad++;
          cyc_since = 0;
          edges++;
          if (lead == exp_latch_lead(e_cpha)) begin
            mo_acc = {mo_acc[6:0], mosi_prev};
            mo_bits++;
            if ((mo_bits % 8) == 0 && (mo_bits / 8) <= MAXB) mo_bytes[mo_bits / 8 - 1] = mo_acc;
            sl_bit++;
          end
        end else begin
          cyc_since++;
        end
        if (sl_bit < n_len * 8) miso = sl_bytes[sl_bit / 8][7 - (sl_bit % 8)];
        else miso = 1'b0;
        if (rx_valid) begin
          if (rx_cnt < MAXB) rx_got[rx_cnt] = rx_data;
          rx_cnt++;
        end
        if (done) done_cnt++;
        cs_prev = cs_n; sclk_prev = sclk; mosi_prev = mosi;
      end
    end
  end

  task automatic run_xfer(input logic [2:0] hi, input logic [1:0] m, input int div,
                          input int len, input int pre, input bit scramble, input string tag);
    logic [3:0] c;
    int toggles, wait_cyc;
    logic s_last;
    c = exp_cfg(hi, m);
    @(negedge clk);
    ctrl_hi = hi; mode = m; clk_div = 8'(div); xfer_len = 8'(len); prepend_len = 8'(pre);
    for (int i = 0; i < MAXB; i++) begin
      tx_bytes[i] = 8'($urandom); sl_bytes[i] = 8'($urandom);
      mo_bytes[i] = 8'h00; rx_got[i] = 8'h00;
    end
    e_cpol = c[3]; e_cpha = c[2]; e_ext = c[1];
    n_len = len; n_div = div;
    edges = 0; mo_bits = 0; rx_cnt = 0; tx_idx = 0; sl_bit = 0; done_cnt = 0;
    timing_bad = 0; spacing_bad = 0; cyc_since = 0;
    // R6: idle behaviour of the clock before the transfer
    toggles = 0;
    @(negedge clk); s_last = sclk;
    for (int i = 0; i < 2 * (div + 1) + 2 + int'($urandom_range(0, 3)); i++) begin
      @(negedge clk);
      if (sclk != s_last) toggles++;
      s_last = sclk;
    end
    if (c[0]) chk(toggles == 0 && sclk == e_cpol, {tag, " R6"}, "gated idle sclk",
                  int'(sclk) + 2 * toggles, int'(e_cpol));
    else chk(toggles >= 1, {tag, " R6"}, "free-running idle toggles", toggles, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      ctrl_hi = 3'($urandom); mode = 2'($urandom);
      xfer_len = 8'($urandom); prepend_len = 8'($urandom);
    end
    wait_cyc = 0;
    while (done_cnt == 0 && wait_cyc < 20000) begin
      @(negedge clk);
      wait_cyc++;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, {tag, " R10"}, "done pulses", done_cnt, 1);
    chk(edges == 16 * len, {tag, " R7"}, "sclk edges while selected", edges, 16 * len);
    chk(spacing_bad == 0, {tag, " R7"}, "edge spacing errors", spacing_bad, 0);
    chk(timing_bad == 0, {tag, " R3"}, "mosi off launch edge", timing_bad, 0);
    for (int i = 0; i < len; i++)
      chk(mo_bytes[i] == tx_bytes[i], {tag, " R3,R7"}, "mosi byte",
          int'(mo_bytes[i]), int'(tx_bytes[i]));
    chk(tx_idx == len, {tag, " R9"}, "bytes taken", tx_idx, len);
    chk(rx_cnt == len - pre, {tag, " R8"}, "rx strobes", rx_cnt, len - pre);
    for (int j = 0; j < len - pre && j < rx_cnt; j++)
      chk(rx_got[j] == sl_bytes[pre + j], {tag, " R3,R8"}, "rx byte",
          int'(rx_got[j]), int'(sl_bytes[pre + j]));
    chk(cs_n == 1'b1, {tag, " R10"}, "cs_n released", int'(cs_n), 1);
    ctrl_hi = hi; mode = m;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5e1f_0a17));
    n_len = 0; n_div = 0; e_cpol = 0; e_cpha = 0; e_ext = 0;
    rst_n = 1'b0; start = 1'b0; ctrl_hi = 3'b000; mode = 2'b00;
    clk_div = 8'd1; xfer_len = 8'd0; prepend_len = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "cs_n/sclk after reset", {cs_n, sclk}, 2'b10);
    chk(!done && !err && !rx_valid && !tx_ready, "R1", "strobes after reset",
        {done, err, rx_valid, tx_ready}, 0);

    // R11: zero length
    @(negedge clk);
    xfer_len = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && cs_n == 1'b1, "R11", "err on zero length", {err, cs_n}, 2'b11);
    repeat (4) @(negedge clk);
    chk(err == 1'b0 && cs_n == 1'b1 && done == 1'b0, "R11", "no transfer after refusal",
        {err, cs_n, done}, 3'b010);

    // R3, R4: all eight polarity/phase/extension combinations, gated
    for (int k = 0; k < 8; k++)
      run_xfer({1'b1, k[2], 1'b1}, k[1:0], 1, 3, 1, 1'b0, "R3,R4 mode-walk");

    // R5: valid clear overrides mode and other bits
    run_xfer(3'b010, 2'b11, 2, 2, 0, 1'b0, "R5 default");
    run_xfer(3'b000, 2'b10, 0, 1, 0, 1'b0, "R5 default-div0");

    // R6: free-running idle clock in same-edge and normal modes
    run_xfer(3'b110, 2'b01, 3, 2, 0, 1'b0, "R6 ungated-ext");
    run_xfer(3'b100, 2'b10, 2, 3, 1, 1'b0, "R6 ungated");

    // R8: prepend boundaries
    run_xfer(3'b101, 2'b00, 0, 4, 4, 1'b0, "R8 all-prepend");
    run_xfer(3'b101, 2'b11, 1, MAXB, 0, 1'b0, "R8 no-prepend");

    // R12 and random mix
    for (int r = 0; r < 14; r++) begin
      int len, pre;
      len = int'($urandom_range(1, MAXB));
      pre = int'($urandom_range(0, len));
      run_xfer({1'b1, 2'($urandom)}, 2'($urandom), int'($urandom_range(0, 3)),
               len, pre, (r % 2) == 1, (r % 2) == 1 ? "R12 scrambled" : "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule